// File: doc/BRIEF.md
# Synthesizer divider command register file

This block is the configuration front end of a frequency synthesizer. A plain register bus (address, write strobe, write data, read strobe, read data) reaches two staging registers and a write-only command port. A separate set of live divider latches drives the PLL: a 10-bit feedback divider, a 3-bit post-divider A, a 1-bit post-divider B and a 1-bit pre-divider.

Software prepares a divider setting in the staging registers and then issues an apply command to copy it into the live latches in one update. A capture command copies the live latches back into staging so a read returns what the PLL is really running. Step-up and step-down commands change the live feedback divider by one for fast frequency margining, without touching staging. No setting is checked for validity. The bus has no back-pressure: every write takes effect on the next clock edge and read data is returned in the same cycle as the read strobe.

Top module: `syn_div_regfile`

## Requirements
- R1: After reset, all staging fields and all live divider outputs are zero.
- R2: A write to address 0x00 stores M[7:0] in staging, and a read of 0x00 returns it; writing staging alone never changes the live divider outputs.
- R3: Address 0x01 is read/write with bit7..6 = M[9:8], bits5..3 = NA[2:0], bit2 = NB, bit1 = P.
- R4: Bit 0 of a read of 0x01 always equals the current `pll_lock` input; the value written to that bit has no effect.
- R5: Writing 0x01 to address 0xF0 (apply) copies staging M, NA, NB and P into the live outputs on the clock edge that takes the write.
- R6: Writing 0x02 to address 0xF0 (capture) copies the live M, NA, NB and P into staging on the clock edge that takes the write.
- R7: Writing 0x03 to address 0xF0 (step up) adds one to the live M modulo 1024 (1023 wraps to 0); staging is unchanged.
- R8: Writing 0x04 to address 0xF0 (step down) subtracts one from the live M modulo 1024 (0 wraps to 1023); staging is unchanged.
- R9: Any other value written to 0xF0 changes neither staging nor live state.
- R10: `rd_data` is 0x00 while `rd_en` is low, and a read of 0xF0 or of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, same cycle as `bus_rd` |
| pll_lock | input | 1 | Lock indication from the PLL |
| fb_div | output | 10 | Live feedback divider M |
| post_a | output | 3 | Live post-divider NA |
| post_b | output | 1 | Live post-divider NB |
| pre_div | output | 1 | Live pre-divider P |

## Verification
The bench builds the block with its default addresses (0x00, 0x01, 0xF0) and the fixed 10-bit feedback field, so both wrap points of the step commands, 1023 up to 0 and 0 down to 1023, are reached in a few cycles after an apply. With those values the unmapped addresses 0x02 and 0xFF and the unused command codes 0x00, 0x05 and 0xFF are all driven, and the lock bit is toggled under reads of the upper staging register.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;
  localparam int M_W    = 10;
  localparam int NA_W   = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int M_LO_W = DATA_W;
  localparam int M_HI_W = M_W - M_LO_W;

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [NA_W-1:0] na;
    logic            nb;
    logic            p;
  } div_cfg_t;

  typedef enum logic [DATA_W-1:0] {
    CMD_APPLY   = 8'h01,
    CMD_CAPTURE = 8'h02,
    CMD_STEP_UP = 8'h03,
    CMD_STEP_DN = 8'h04
  } cmd_e;
endpackage

// File: rtl/syn_bus_decode.sv
module syn_bus_decode
  import syn_div_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h01,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              do_apply,
  output logic              do_capture,
  output logic              do_up,
  output logic              do_dn
);
  logic cmd_hit;

  always_comb begin
    wr_lo      = bus_wr && (bus_addr == LO_ADDR);
    wr_hi      = bus_wr && (bus_addr == HI_ADDR);
    cmd_hit    = bus_wr && (bus_addr == CMD_ADDR);
    do_apply   = 1'b0;
    do_capture = 1'b0;
    do_up      = 1'b0;
    do_dn      = 1'b0;
    if (cmd_hit) begin
      case (bus_wdata)
        CMD_APPLY:   do_apply   = 1'b1;
        CMD_CAPTURE: do_capture = 1'b1;
        CMD_STEP_UP: do_up      = 1'b1;
        CMD_STEP_DN: do_dn      = 1'b1;
        default: ;
      endcase
    end
  end

  // R9: at most one command strobe per cycle, and none without a command write
  assert_single_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_apply, do_capture, do_up, do_dn}));
  assert_cmd_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_apply || do_capture || do_up || do_dn) |-> (bus_wr && bus_addr == CMD_ADDR));
endmodule

// File: rtl/syn_stage_regs.sv
module syn_stage_regs
  import syn_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              do_capture,
  input  div_cfg_t          live_cfg,
  output div_cfg_t          stage_cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_cfg <= '0;
    end else if (do_capture) begin
      stage_cfg <= live_cfg;
    end else begin
      if (wr_lo) stage_cfg.m[M_LO_W-1:0] <= wdata;
      if (wr_hi) begin
        stage_cfg.m[M_W-1:M_LO_W] <= wdata[7:6];
        stage_cfg.na              <= wdata[5:3];
        stage_cfg.nb              <= wdata[2];
        stage_cfg.p               <= wdata[1];
      end
    end
  end

  // R6: capture lands the live value in staging
  assert_capture_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_capture |=> (stage_cfg == $past(live_cfg)));
  // R7/R8: staging holds unless written or captured
  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi || do_capture) |=> $stable(stage_cfg));
endmodule

// File: rtl/syn_live_divs.sv
module syn_live_divs
  import syn_div_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     do_apply,
  input  logic     do_up,
  input  logic     do_dn,
  input  div_cfg_t stage_cfg,
  output div_cfg_t live_cfg
);
  logic [M_W-1:0] m_next;

  always_comb begin
    m_next = live_cfg.m;
    if (do_up)      m_next = live_cfg.m + M_W'(1);
    else if (do_dn) m_next = live_cfg.m - M_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        live_cfg <= '0;
    else if (do_apply) live_cfg <= stage_cfg;
    else               live_cfg.m <= m_next;
  end

  assert_apply_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_apply |=> (live_cfg == $past(stage_cfg)));
  assert_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_up |=> (live_cfg.m == M_W'($past(live_cfg.m) + 1'b1)) && $stable(live_cfg.na));
  assert_step_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_dn |=> (live_cfg.m == M_W'($past(live_cfg.m) - 1'b1)) && $stable(live_cfg.p));
  assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_apply || do_up || do_dn) |=> $stable(live_cfg));
endmodule

// File: rtl/syn_div_regfile.sv
module syn_div_regfile
  import syn_div_pkg::*;
#(
  parameter logic [7:0] LO_ADDR  = 8'h00,
  parameter logic [7:0] HI_ADDR  = 8'h01,
  parameter logic [7:0] CMD_ADDR = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] rd_data,
  input  logic       pll_lock,
  output logic [9:0] fb_div,
  output logic [2:0] post_a,
  output logic       post_b,
  output logic       pre_div
);
  logic     wr_lo, wr_hi, do_apply, do_capture, do_up, do_dn;
  div_cfg_t stage_cfg, live_cfg;

  syn_bus_decode #(
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .do_apply(do_apply), .do_capture(do_capture), .do_up(do_up), .do_dn(do_dn)
  );

  syn_stage_regs u_stage (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .do_capture(do_capture), .live_cfg(live_cfg), .stage_cfg(stage_cfg)
  );

  syn_live_divs u_live (
    .clk(clk), .rst_n(rst_n), .do_apply(do_apply), .do_up(do_up), .do_dn(do_dn),
    .stage_cfg(stage_cfg), .live_cfg(live_cfg)
  );

  always_comb begin
    rd_data = '0;
    if (bus_rd) begin
      if (bus_addr == LO_ADDR)
        rd_data = stage_cfg.m[M_LO_W-1:0];
      else if (bus_addr == HI_ADDR)
        rd_data = {stage_cfg.m[M_W-1:M_LO_W], stage_cfg.na, stage_cfg.nb,
                   stage_cfg.p, pll_lock};
    end
  end

  assign fb_div  = live_cfg.m;
  assign post_a  = live_cfg.na;
  assign post_b  = live_cfg.nb;
  assign pre_div = live_cfg.p;

  // R1: first cycle after reset release shows cleared live outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (fb_div == '0 && post_a == '0 && !post_b && !pre_div));
endmodule

// File: tb/sim_syn_div_regfile.sv
module sim_syn_div_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic       pll_lock = 1'b0;
  logic [7:0] rd_data;
  logic [9:0] fb_div;
  logic [2:0] post_a;
  logic       post_b, pre_div;

  int vectors = 0;
  int misses  = 0;

  // reference model state
  int sm = 0, sna = 0, snb = 0, sp = 0;
  int lm = 0, lna = 0, lnb = 0, lp = 0;

  always #4 clk = ~clk;

  syn_div_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
    .pll_lock(pll_lock), .fb_div(fb_div), .post_a(post_a),
    .post_b(post_b), .pre_div(pre_div)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      sm = 0; sna = 0; snb = 0; sp = 0; lm = 0; lna = 0; lnb = 0; lp = 0;
    end else if (bus_wr) begin
      if (bus_addr == 8'h00) sm = (sm & 'h300) | bus_wdata;
      else if (bus_addr == 8'h01) begin
        sm  = (sm & 'hFF) | ((bus_wdata >> 6) << 8);
        sna = (bus_wdata >> 3) & 7;
        snb = (bus_wdata >> 2) & 1;
        sp  = (bus_wdata >> 1) & 1;
      end else if (bus_addr == 8'hF0) begin
        case (bus_wdata)
          8'h01: begin lm = sm; lna = sna; lnb = snb; lp = sp; end
          8'h02: begin sm = lm; sna = lna; snb = lnb; sp = lp; end
          8'h03: lm = (lm + 1) % 1024;
          8'h04: lm = (lm + 1023) % 1024;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd();
    if (!bus_rd) return 0;
    if (bus_addr == 8'h00) return sm & 'hFF;
    if (bus_addr == 8'h01)
      return ((sm >> 8) << 6) | (sna << 3) | (snb << 2) | (sp << 1) | int'(pll_lock);
    return 0;
  endfunction

  task automatic compare(string tag);
    int er;
    er = exp_rd();
    vectors++;
    if (fb_div !== 10'(lm) || post_a !== 3'(lna) || post_b !== 1'(lnb) ||
        pre_div !== 1'(lp) || rd_data !== 8'(er)) begin
      misses++;
      $display("FAIL %s: got m=%0d na=%0d nb=%0d p=%0d rd=%02h, expected m=%0d na=%0d nb=%0d p=%0d rd=%02h",
               tag, fb_div, post_a, post_b, pre_div, rd_data, lm, lna, lnb, lp, er);
    end
  endtask

  // drive at negedge, compare, take edge, compare the settled state
  task automatic step(string tag, logic [7:0] a, logic w, logic [7:0] d, logic r);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
    #1 compare(tag);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    #1 compare(tag);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    step(tag, a, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 compare("R1 reset");
    rd("R1 reset lo", 8'h00);
    rd("R1 reset hi", 8'h01);
    // R2 low staging write, live untouched
    step("R2 write lo", 8'h00, 1'b1, 8'hA5, 1'b0);
    rd("R2 read lo", 8'h00);
    // R3 upper layout
    step("R3 write hi", 8'h01, 1'b1, 8'b10_101_1_1_0, 1'b0);
    rd("R3 read hi", 8'h01);
    // R4 lock bit
    pll_lock = 1'b1;
    rd("R4 lock high", 8'h01);
    step("R4 write lock bit", 8'h01, 1'b1, 8'b01_010_0_1_1, 1'b0);
    pll_lock = 1'b0;
    rd("R4 lock low", 8'h01);
    // R5 apply
    step("R5 apply", 8'hF0, 1'b1, 8'h01, 1'b0);
    step("R2 stage only", 8'h00, 1'b1, 8'h3C, 1'b0);
    step("R2 stage only hi", 8'h01, 1'b1, 8'hFE, 1'b0);
    // R6 capture
    step("R6 capture", 8'hF0, 1'b1, 8'h02, 1'b0);
    rd("R6 read lo", 8'h00);
    rd("R6 read hi", 8'h01);
    // R7 step up to wrap
    step("R7 set lo", 8'h00, 1'b1, 8'hFE, 1'b0);
    step("R7 set hi", 8'h01, 1'b1, 8'hC0, 1'b0);
    step("R7 apply 1022", 8'hF0, 1'b1, 8'h01, 1'b0);
    step("R7 up", 8'hF0, 1'b1, 8'h03, 1'b0);
    step("R7 up wrap", 8'hF0, 1'b1, 8'h03, 1'b0);
    step("R7 up again", 8'hF0, 1'b1, 8'h03, 1'b0);
    rd("R7 staging kept lo", 8'h00);
    rd("R7 staging kept hi", 8'h01);
    // R8 step down wrap
    step("R8 down", 8'hF0, 1'b1, 8'h04, 1'b0);
    step("R8 down wrap", 8'hF0, 1'b1, 8'h04, 1'b0);
    step("R8 down again", 8'hF0, 1'b1, 8'h04, 1'b0);
    rd("R8 staging kept", 8'h00);
    // R9 unused codes
    step("R9 code 00", 8'hF0, 1'b1, 8'h00, 1'b0);
    step("R9 code 05", 8'hF0, 1'b1, 8'h05, 1'b0);
    step("R9 code FF", 8'hF0, 1'b1, 8'hFF, 1'b0);
    step("R9 unmapped write", 8'h02, 1'b1, 8'h01, 1'b0);
    rd("R9 staging kept lo", 8'h00);
    rd("R9 staging kept hi", 8'h01);
    // R10 reads returning zero
    rd("R10 read cmd", 8'hF0);
    rd("R10 read unmapped", 8'h02);
    rd("R10 read FF", 8'hFF);
    step("R10 no strobe", 8'h00, 1'b0, 8'h00, 1'b0);
    // R1 reset mid-run
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1 compare("R1 second reset");
    rd("R1 second reset hi", 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule